// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

This block gives a timer two independent channels that share one free-running counter, which comes in from outside the block. Each channel can time-stamp a pin edge by copying the counter into its value register. It can also act on its pin when the counter reaches the value register: it can toggle the pin, drive it high or drive it low. Software reaches the two control registers, the two value registers and a general-purpose pin register over a simple strobed register bus. Each channel has its own interrupt request line.

A channel's event flag can only be cleared by a handshake. Software first reads the control register and sees the flag set, then writes 0 to the flag. If a new event lands between the read and the write, the write is dropped, so no event is lost. Channel 0 also has a buffered compare mode. In that mode it compares against its own value register and channel 1's value register in turn. Channel 1's control register is then locked, and channel 1's pin returns to general-purpose use.

Top module: `tmr_chpair`

## Requirements
- R1: After reset, both control registers, the pin register, both interrupt lines and both pin output enables read 0.
- R2: A channel whose control has mode bit (bit 4) at 0 and edge field (bits 3:2) not 00 captures pin edges. Field 01 selects rising edges, 10 falling edges and 11 both. The pin passes through a two-flop synchronizer, so the flag rises on the third clock edge after the pin changes. On that same edge the counter value is loaded into the channel's value register. The channel's output enable is 0 in this mode.
- R3: With mode bit 1 and the field not 00, a clock edge on which the counter equals the compared value sets the flag and acts on the pin: 01 toggles it, 10 drives it low, 11 drives it high. The output enable is 1 in this mode.
- R4: The flag (bit 7) is cleared by a 0 write to bit 7 only when the most recent control access was a read that returned the flag set. A 0 write without such a read leaves the flag set.
- R5: If an event occurs between the arming read and the 0 write, the write leaves the flag set.
- R6: Writing 1 to the flag bit never sets it.
- R7: A channel's interrupt line is high exactly while its flag and its enable bit (bit 6) are both 1.
- R8: With the edge field at 00, pin edges and counter matches leave the flag clear. The pin is then driven by the pin register at address 4: bits 1:0 are the output values and bits 3:2 are the output enables.
- R9: Setting channel 0 bit 5, with a nonzero edge field, starts buffered compare. Matches alternate between value register 0 (taken first) and value register 1. Writes to channel 1's control register are ignored, and pin 1 follows the pin register.
- R10: Register addresses are: 0 channel 0 control, 1 channel 0 value, 2 channel 1 control, 3 channel 1 value, 4 pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| cnt_i | input | 16 | Shared free-running counter value |
| pin_in | input | 2 | Channel pin input levels |
| pin_out | output | 2 | Channel pin output levels |
| pin_oe | output | 2 | Channel pin output enables |
| irq_o | output | 2 | Per-channel interrupt requests |

## Verification
The hardest case to reach is an event that falls inside the clear handshake. The stimulus first arms the handshake with a read that returns the flag set. It then drives the counter onto the compare value for a single cycle, and only after that issues the 0 write, then reads back to confirm the flag held. Buffered alternation is driven the same way: the counter is pulsed at each value register in turn. A pulse at the inactive register must leave the pin unchanged.

// File: rtl/tmr_chpair_pkg.sv
package tmr_chpair_pkg;
   localparam int unsigned AW     = 3;
   localparam int unsigned CTRL_W = 8;
   localparam int unsigned PIO_W  = 4;
   localparam int unsigned B_FLAG = 7;
   localparam int unsigned B_IE   = 6;
   localparam int unsigned B_BUF  = 5;
   localparam int unsigned B_MSA  = 4;
   localparam int unsigned B_ELS  = 2;
   localparam logic [AW-1:0] A_PIO = 3'd4;
   typedef enum logic [1:0] {
      ELS_OFF  = 2'b00,
      ELS_TOG  = 2'b01,
      ELS_LOW  = 2'b10,
      ELS_HIGH = 2'b11
   } els_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_chpair_pkg::*;
#(
   parameter int unsigned CW      = 16,
   parameter bit          HAS_BUF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic [CW-1:0]     cmp_val_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              ctrl_rd_i,
   input  logic              ctrl_wr_i,
   input  logic              val_wr_i,
   input  logic [CW-1:0]     wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [CW-1:0]     val_o,
   output logic              irq_o,
   output logic              pin_o,
   output logic              capt_o,
   output logic              cmp_o,
   output logic              match_o
);
   generate
      if (CW < CTRL_W) begin : g_bad_cw
         $error("tmr_channel: CW must hold the control byte");
      end
   endgenerate

   logic          flag_q, ie_q, msa_q, armed_q, pin_q, buf_q;
   logic [1:0]    els_q;
   logic [CW-1:0] val_q;
   logic          active, cap_evt, evt, wr_ok, clr_ok;

   assign active  = en_i && (els_q != ELS_OFF);
   assign capt_o  = active && !msa_q && !buf_q;
   assign cmp_o   = active && (msa_q || buf_q);
   assign cap_evt = capt_o && ((els_q[0] && rise_i) || (els_q[1] && fall_i));
   assign match_o = cmp_o && (cnt_i == cmp_val_i);
   assign evt     = cap_evt || match_o;
   assign wr_ok   = ctrl_wr_i && en_i;
   assign clr_ok  = wr_ok && !wdata_i[B_FLAG] && armed_q && !evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         ie_q    <= 1'b0;
         msa_q   <= 1'b0;
         els_q   <= ELS_OFF;
         val_q   <= '0;
         pin_q   <= 1'b0;
      end else begin
         if (evt)         flag_q <= 1'b1;
         else if (clr_ok) flag_q <= 1'b0;

         if (evt)                        armed_q <= 1'b0;
         else if (ctrl_rd_i && flag_q)   armed_q <= 1'b1;
         else if (ctrl_wr_i)             armed_q <= 1'b0;

         if (wr_ok) begin
            ie_q  <= wdata_i[B_IE];
            msa_q <= wdata_i[B_MSA];
            els_q <= wdata_i[B_ELS +: 2];
         end

         if (cap_evt)       val_q <= cnt_i;
         else if (val_wr_i) val_q <= wdata_i;

         if (match_o) begin
            unique case (els_q)
               ELS_TOG:  pin_q <= ~pin_q;
               ELS_LOW:  pin_q <= 1'b0;
               ELS_HIGH: pin_q <= 1'b1;
               default:  pin_q <= pin_q;
            endcase
         end
      end
   end

   generate
      if (HAS_BUF) begin : g_buf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     buf_q <= 1'b0;
            else if (wr_ok) buf_q <= wdata_i[B_BUF];
         end
      end else begin : g_nobuf
         assign buf_q = 1'b0;
      end
   endgenerate

   assign ctrl_o = {flag_q, ie_q, buf_q, msa_q, els_q, 2'b00};
   assign val_o  = val_q;
   assign irq_o  = flag_q & ie_q;
   assign pin_o  = pin_q;

   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> flag_q); // R2
   AST_CAPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (val_q == $past(cnt_i))); // R2
   AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> flag_q); // R3
   AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q) |=> flag_q); // R4
   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && evt) |=> flag_q); // R5
   AST_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && wdata_i[B_FLAG] && !flag_q && !evt) |=> !flag_q); // R6
endmodule

// File: rtl/tmr_chpair.sv
module tmr_chpair
   import tmr_chpair_pkg::*;
#(
   parameter int unsigned CW       = 16,
   parameter int unsigned SYNC_STG = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [CW-1:0] bus_wdata,
   output logic [CW-1:0] bus_rdata,
   input  logic [CW-1:0] cnt_i,
   input  logic [1:0]    pin_in,
   output logic [1:0]    pin_out,
   output logic [1:0]    pin_oe,
   output logic [1:0]    irq_o
);
   localparam int unsigned NCH = 2;

   logic [CTRL_W-1:0] ctrl_w  [NCH];
   logic [CW-1:0]     val_w   [NCH];
   logic [NCH-1:0]    pin_w, capt_w, cmp_w, match_w;
   logic [PIO_W-1:0]  pio_q;
   logic              buf_on, bsel_q;

   assign buf_on = ctrl_w[0][B_BUF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bsel_q <= 1'b0;
      else if (!buf_on) bsel_q <= 1'b0;
      else if (match_w[0]) bsel_q <= ~bsel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           pio_q <= '0;
      else if (bus_wr && bus_addr == A_PIO) pio_q <= bus_wdata[PIO_W-1:0];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [AW-1:0] A_CTRL = AW'(2*i);
      localparam logic [AW-1:0] A_VAL  = AW'(2*i + 1);
      logic          rise, fall, en;
      logic [CW-1:0] cmp_val;

      if (i == 0) begin : g_sel
         assign en      = 1'b1;
         assign cmp_val = (buf_on && bsel_q) ? val_w[1] : val_w[0];
      end else begin : g_plain
         assign en      = !buf_on;
         assign cmp_val = val_w[i];
      end

      tmr_edge_sync #(.STAGES(SYNC_STG)) i_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(pin_in[i]),
         .rise_o(rise), .fall_o(fall));

      tmr_channel #(.CW(CW), .HAS_BUF(i == 0)) i_ch (
         .clk(clk), .rst_n(rst_n), .en_i(en), .cnt_i(cnt_i),
         .cmp_val_i(cmp_val), .rise_i(rise), .fall_i(fall),
         .ctrl_rd_i(bus_rd && bus_addr == A_CTRL),
         .ctrl_wr_i(bus_wr && bus_addr == A_CTRL),
         .val_wr_i(bus_wr && bus_addr == A_VAL),
         .wdata_i(bus_wdata), .ctrl_o(ctrl_w[i]), .val_o(val_w[i]),
         .irq_o(irq_o[i]), .pin_o(pin_w[i]), .capt_o(capt_w[i]),
         .cmp_o(cmp_w[i]), .match_o(match_w[i]));

      assign pin_oe[i]  = capt_w[i] ? 1'b0 : (cmp_w[i] ? 1'b1 : pio_q[2+i]);
      assign pin_out[i] = cmp_w[i] ? pin_w[i] : pio_q[i];
   end

   always_comb begin
      unique case (bus_addr)
         3'd0:    bus_rdata = {{(CW-CTRL_W){1'b0}}, ctrl_w[0]};
         3'd1:    bus_rdata = val_w[0];
         3'd2:    bus_rdata = {{(CW-CTRL_W){1'b0}}, ctrl_w[1]};
         3'd3:    bus_rdata = val_w[1];
         A_PIO:   bus_rdata = {{(CW-PIO_W){1'b0}}, pio_q};
         default: bus_rdata = '0;
      endcase
   end

   AST_CH1_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_on && bus_wr && bus_addr == 3'd2) |=> $stable(ctrl_w[1])); // R9
   AST_BSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_on |=> !bsel_q); // R9
endmodule

// File: tb/test_tmr_chpair.sv
module test_tmr_chpair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] cnt_i = 16'h5555;
   logic [1:0]  pin_in = '0;
   logic [1:0]  pin_out, pin_oe, irq_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   localparam logic [15:0] IDLE = 16'h7777;
   // {edge field, compare value, expected pin 0 after the match}
   localparam logic [18:0] VEC [6] = '{
      {2'b11, 16'd100,  1'b1},
      {2'b01, 16'd200,  1'b0},
      {2'b01, 16'd300,  1'b1},
      {2'b10, 16'd400,  1'b0},
      {2'b11, 16'hFFFF, 1'b1},
      {2'b01, 16'h0000, 1'b0}
   };

   tmr_chpair i_tmr_chpair (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_i(cnt_i), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_o(irq_o));

   always #5 clk = ~clk;

   function automatic logic [15:0] ctl(input logic f, input logic ie,
      input logic b, input logic m, input logic [1:0] els);
      return {8'h00, f, ie, b, m, els, 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] v);
      @(negedge clk);
      cnt_i = v;
      @(negedge clk);
      cnt_i = IDLE;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d, keep;
      logic        p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R10: reset state of every register and output
      bus_read(3'd0, d); chk("R1 ctrl0", d, 16'h0000);
      bus_read(3'd2, d); chk("R1 ctrl1", d, 16'h0000);
      bus_read(3'd4, d); chk("R1 R10 pin register", d, 16'h0000);
      chk("R1 irq", {14'h0, irq_o}, 16'h0);
      chk("R1 pin_oe", {14'h0, pin_oe}, 16'h0);

      // R3: table of compare actions on channel 0
      cnt_i = IDLE;
      for (int k = 0; k < 6; k++) begin
         bus_write(3'd0, ctl(0, 0, 0, 1, VEC[k][18:17]));
         bus_write(3'd1, VEC[k][16:1]);
         pulse(VEC[k][16:1]);
         chk($sformatf("R3 pin0 vec%0d", k), {15'h0, pin_out[0]}, {15'h0, VEC[k][0]});
         chk($sformatf("R3 oe0 vec%0d", k), {15'h0, pin_oe[0]}, 16'h1);
         bus_read(3'd0, d);
         chk($sformatf("R3 flag vec%0d", k), {15'h0, d[7]}, 16'h1);
      end

      // R6, R7: writing 1 keeps the flag, irq follows flag and enable
      bus_write(3'd0, ctl(1, 1, 0, 1, 2'b01));
      chk("R7 irq0 raised", {15'h0, irq_o[0]}, 16'h1);
      // R4: 0 write with no arming read since the last write
      bus_write(3'd0, ctl(0, 1, 0, 1, 2'b01));
      bus_read(3'd0, d);
      chk("R4 blind clear ignored", {15'h0, d[7]}, 16'h1);
      bus_write(3'd0, ctl(0, 1, 0, 1, 2'b01));
      bus_read(3'd0, d);
      chk("R4 handshake clears", {15'h0, d[7]}, 16'h0);
      chk("R7 irq0 dropped", {15'h0, irq_o[0]}, 16'h0);
      bus_write(3'd0, ctl(1, 1, 0, 1, 2'b01));
      bus_read(3'd0, d);
      chk("R6 write one no set", {15'h0, d[7]}, 16'h0);

      // R5: event between arming read and 0 write
      pulse(16'h0000);
      bus_read(3'd0, d);
      chk("R5 flag set", {15'h0, d[7]}, 16'h1);
      pulse(16'h0000);
      bus_write(3'd0, ctl(0, 1, 0, 1, 2'b01));
      bus_read(3'd0, d);
      chk("R5 write after event ignored", {15'h0, d[7]}, 16'h1);
      bus_write(3'd0, ctl(0, 0, 0, 1, 2'b01));
      bus_read(3'd0, d);
      chk("R5 later clear works", {15'h0, d[7]}, 16'h0);

      // R2: rising-edge capture on channel 1 with a held counter
      bus_write(3'd2, ctl(0, 1, 0, 0, 2'b01));
      chk("R2 oe1 capture", {15'h0, pin_oe[1]}, 16'h0);
      cnt_i = 16'h1234;
      @(negedge clk); pin_in[1] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R2 no flag after two edges", {15'h0, irq_o[1]}, 16'h0);
      @(negedge clk);
      chk("R2 flag on third edge", {15'h0, irq_o[1]}, 16'h1);
      cnt_i = IDLE;
      bus_read(3'd3, d);
      chk("R2 captured count", d, 16'h1234);
      bus_read(3'd2, d);
      bus_write(3'd2, ctl(0, 1, 0, 0, 2'b01));
      @(negedge clk); pin_in[1] = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 falling edge ignored", {15'h0, irq_o[1]}, 16'h0);

      // R8: edge field 00 does nothing, pin register drives pin 1
      bus_write(3'd2, ctl(0, 1, 0, 0, 2'b00));
      bus_write(3'd4, 16'h000A);
      chk("R8 pin1 from register", {15'h0, pin_out[1]}, 16'h1);
      chk("R8 oe1 from register", {15'h0, pin_oe[1]}, 16'h1);
      @(negedge clk); pin_in[1] = 1'b1;
      repeat (5) @(negedge clk);
      pin_in[1] = 1'b0;
      bus_write(3'd3, 16'h0055);
      pulse(16'h0055);
      repeat (4) @(negedge clk);
      chk("R8 no event when off", {15'h0, irq_o[1]}, 16'h0);

      // R9: buffered compare on channel 0
      bus_write(3'd4, 16'h0000);
      bus_write(3'd2, ctl(0, 0, 0, 1, 2'b11));
      chk("R9 oe1 in compare", {15'h0, pin_oe[1]}, 16'h1);
      bus_write(3'd3, 16'h0020);
      bus_write(3'd1, 16'h0010);
      bus_write(3'd0, ctl(0, 0, 1, 1, 2'b01));
      chk("R9 pin1 back to register", {15'h0, pin_oe[1]}, 16'h0);
      @(negedge clk); p0 = pin_out[0];
      pulse(16'h0020);
      chk("R9 inactive register no match", {15'h0, pin_out[0]}, {15'h0, p0});
      pulse(16'h0010);
      chk("R9 first match on reg0", {15'h0, pin_out[0]}, {15'h0, ~p0});
      pulse(16'h0010);
      chk("R9 reg0 now inactive", {15'h0, pin_out[0]}, {15'h0, ~p0});
      pulse(16'h0020);
      chk("R9 second match on reg1", {15'h0, pin_out[0]}, {15'h0, p0});
      bus_read(3'd2, keep);
      bus_write(3'd2, ctl(0, 1, 0, 0, 2'b01));
      bus_read(3'd2, d);
      chk("R9 ch1 ctrl locked", d, keep);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule